// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit effective address from up to three terms: a base register value, an index register value multiplied by 1, 2, 4 or 8, and a full-width signed displacement. Either register term can be switched off with its own enable flag, in which case it adds nothing. The sum wraps modulo 2^32, so a negative displacement is an ordinary two's-complement addend.

Each request carries a routing flag. A normal request sends the address to the memory side, where `mem_valid` pulses with the address on `mem_addr`. An address-only request computes the same address but hands it back as a result value on `res_data` with `res_valid`, and the memory side sees nothing. Results appear one clock after the request, and one request can be accepted every cycle.

The output stage is a small state register with three named states. `OUT_NONE` means no output this cycle. `OUT_MEM` means a memory address is presented. `OUT_LEA` means an address-only result is presented. Each cycle the next state is chosen from the request. The transition *to_none* is taken when no request is valid. The transition *to_mem* is taken for a valid request with the routing flag clear. The transition *to_lea* is taken for a valid request with the routing flag set. Any state can move to any state.

Top module: `eagen_top`

## Requirements
- R1: After reset, `mem_valid` and `res_valid` are 0 and `mem_addr` and `res_data` are 0.
- R2: With only the base enabled, the address is base + displacement.
- R3: With base and index enabled, a scale code of 0, and a displacement of 0, the address is base + index.
- R4: The 2-bit scale code k multiplies the index by 2^k (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). Bits shifted out past bit 31 are lost.
- R5: With all terms enabled, the address is base + (index << k) + displacement.
- R6: A disabled base or index term contributes zero, whatever value sits on its input.
- R7: The sum wraps modulo 2^32, and no overflow is signalled.
- R8: The output valid for a request is asserted exactly one cycle after `req_valid`. In a cycle after no request, both valids are 0.
- R9: When `req_lea` = 1, the address appears on `res_data` with `res_valid` = 1, and `mem_valid` stays 0. When `req_lea` = 0, the address appears on `mem_addr` with `mem_valid` = 1, and `res_valid` stays 0.
- R10: `mem_addr` keeps its last value unless a memory request is taken. `res_data` keeps its last value unless an address-only request is taken.
- R11: `mem_valid` and `res_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_lea | input | 1 | 1 = return the address as a result, 0 = send it to memory |
| base_en | input | 1 | Base term enabled |
| base_val | input | 32 | Base register value |
| index_en | input | 1 | Index term enabled |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Index scale code, multiplier 2^code |
| disp | input | 32 | Signed displacement |
| mem_valid | output | 1 | Memory address valid |
| mem_addr | output | 32 | Memory address |
| res_valid | output | 1 | Address-only result valid |
| res_data | output | 32 | Address-only result value |

## Verification
The bench goes after sums that cross 2^32. Examples are a large negative displacement applied to a small base, and a scaled index whose top bits fall off. A design that saturated, or kept a 33rd bit, would return an address that is wrong by a multiple of 2^32. It feeds garbage on disabled operands; a design that forgot the gating would add that garbage in. It checks every scale code, where an off-by-one shift gives an address off by a factor of two. It also interleaves memory, address-only and idle cycles. A wrong routing or a missing hold would then raise both valids, lose the held address, or overwrite the other output.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_MEM  = 2'd1,
        OUT_LEA  = 2'd2
    } out_state_t;

endpackage

// File: rtl/eagen_gate.sv
module eagen_gate #(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] val,
    output logic [ADDR_W-1:0] term
);
    always_comb begin
        term = en ? val : '0;
    end
endmodule

// File: rtl/eagen_scaler.sv
module eagen_scaler #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  val,
    input  logic [SCALE_W-1:0] sel,
    output logic [ADDR_W-1:0]  scaled
);
    localparam int NUM_SCALES = 1 << SCALE_W;

    logic [ADDR_W-1:0] options [NUM_SCALES];

    for (genvar k = 0; k < NUM_SCALES; k++) begin : g_shift
        assign options[k] = val << k;
    end

    always_comb begin
        scaled = options[sel];
    end
endmodule

// File: rtl/eagen_sum3.sv
module eagen_sum3 #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    input  logic [ADDR_W-1:0] c,
    output logic [ADDR_W-1:0] sum
);
    always_comb begin
        sum = a + b + c;
    end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_lea,
    input  logic               base_en,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               index_en,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic [ADDR_W-1:0]  disp,
    output logic               mem_valid,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  res_data
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] index_scaled;
    logic [ADDR_W-1:0] ea;

    out_state_t state_q, state_d;
    logic [ADDR_W-1:0] mem_addr_q, res_data_q;

    eagen_gate #(.ADDR_W(ADDR_W)) u_base_gate (
        .en(base_en), .val(base_val), .term(base_term)
    );

    eagen_gate #(.ADDR_W(ADDR_W)) u_index_gate (
        .en(index_en), .val(index_val), .term(index_term)
    );

    eagen_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scaler (
        .val(index_term), .sel(scale_sel), .scaled(index_scaled)
    );

    eagen_sum3 #(.ADDR_W(ADDR_W)) u_sum (
        .a(base_term), .b(index_scaled), .c(disp), .sum(ea)
    );

    // next-state selection
    always_comb begin
        state_d = OUT_NONE;
        if (req_valid) begin
            state_d = req_lea ? OUT_LEA : OUT_MEM;
        end
    end

    // state register and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= OUT_NONE;
            mem_addr_q <= '0;
            res_data_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                OUT_MEM:  mem_addr_q <= ea;
                OUT_LEA:  res_data_q <= ea;
                OUT_NONE: ;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_valid = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            OUT_MEM:  mem_valid = 1'b1;
            OUT_LEA:  res_valid = 1'b1;
            OUT_NONE: ;
            default:  ;
        endcase
        mem_addr = mem_addr_q;
        res_data = res_data_q;
    end
endmodule

// File: rtl/eagen_checker.sv
module eagen_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_lea,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_data
);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (mem_valid || res_valid));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_valid && !res_valid));

    assert_lea_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lea) |=> (res_valid && !mem_valid));

    assert_mem_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lea) |=> (mem_valid && !res_valid));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_lea) |=> $stable(mem_addr));

    assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_lea) |=> $stable(res_data));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && res_valid));
endmodule

bind eagen_top eagen_checker #(.ADDR_W(ADDR_W)) u_eagen_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lea(req_lea),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .res_valid(res_valid), .res_data(res_data)
);

// File: tb/eagen_top_bench.sv
module eagen_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_lea = 1'b0;
    logic        base_en = 1'b0, index_en = 1'b0;
    logic [31:0] base_val = '0, index_val = '0, disp = '0;
    logic [1:0]  scale_sel = '0;
    logic        mem_valid, res_valid;
    logic [31:0] mem_addr, res_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_mem = '0, exp_res = '0;

    always #10 clk = ~clk;

    eagen_top u_eagen_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lea(req_lea),
        .base_en(base_en), .base_val(base_val), .index_en(index_en),
        .index_val(index_val), .scale_sel(scale_sel), .disp(disp),
        .mem_valid(mem_valid), .mem_addr(mem_addr),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [31:0] model_ea(input logic be, input logic [31:0] b,
                                             input logic ie, input logic [31:0] i,
                                             input logic [1:0] s, input logic [31:0] d);
        logic [63:0] acc;
        acc = 64'(d);
        if (be) acc = acc + 64'(b);
        if (ie) acc = acc + 64'(i) * (64'd1 << s);
        return acc[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample at the following negedge
    task automatic step(input string req, input logic v, input logic lea,
                        input logic be, input logic [31:0] b,
                        input logic ie, input logic [31:0] i,
                        input logic [1:0] s, input logic [31:0] d);
        logic [31:0] e;
        req_valid = v; req_lea = lea; base_en = be; base_val = b;
        index_en = ie; index_val = i; scale_sel = s; disp = d;
        e = model_ea(be, b, ie, i, s, d);
        if (v && !lea) exp_mem = e;
        if (v && lea)  exp_res = e;
        @(posedge clk);
        @(negedge clk);
        chk({req, " R8 mem_valid"}, 32'(mem_valid), 32'(v && !lea));
        chk({req, " R9 res_valid"}, 32'(res_valid), 32'(v && lea));
        chk({req, " R10 mem_addr"}, mem_addr, exp_mem);
        chk({req, " R10 res_data"}, res_data, exp_res);
        chk("R11 exclusive", 32'(mem_valid && res_valid), 32'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mem_valid", 32'(mem_valid), 32'd0);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 mem_addr", mem_addr, 32'd0);
        chk("R1 res_data", res_data, 32'd0);
        rst_n = 1'b1;

        step("R2 base+disp", 1, 0, 1, 32'h0000_1000, 0, 32'h0, 2'd0, 32'h0000_0010);
        chk("R2 value", mem_addr, 32'h0000_1010);
        step("R3 base+index", 1, 0, 1, 32'h0000_2000, 1, 32'h0000_0030, 2'd0, 32'h0);
        chk("R3 value", mem_addr, 32'h0000_2030);
        for (int k = 0; k < 4; k++) begin
            step("R4 scale", 1, 0, 1, 32'h100, 1, 32'h3, 2'(k), 32'h0);
            chk("R4 value", mem_addr, 32'h100 + (32'h3 << k));
        end
        step("R4 shift-out", 1, 0, 0, 32'h0, 1, 32'h4000_0001, 2'd3, 32'h0);
        chk("R4 shift-out value", mem_addr, 32'h0000_0008);
        step("R5 full", 1, 0, 1, 32'h1000_0000, 1, 32'h10, 2'd2, 32'h0C);
        chk("R5 value", mem_addr, 32'h1000_004C);
        step("R6 gated garbage", 1, 0, 0, 32'hDEAD_BEEF, 0, 32'hCAFE_F00D, 2'd3, 32'h77);
        chk("R6 value", mem_addr, 32'h77);
        step("R7 neg disp", 1, 0, 1, 32'h0000_1000, 0, 32'h0, 2'd0, -32'sd4000000);
        chk("R7 neg value", mem_addr, 32'h0000_1000 - 32'd4000000);
        step("R7 wrap", 1, 0, 1, 32'hFFFF_FFF0, 1, 32'h8, 2'd1, 32'h10);
        chk("R7 wrap value", mem_addr, 32'h0000_0010);
        step("R9 lea", 1, 1, 1, 32'h0000_5000, 1, 32'h2, 2'd2, 32'hFFFF_FFFC);
        chk("R9 lea value", res_data, 32'h0000_5004);
        step("R10 idle", 0, 0, 1, 32'h1234, 1, 32'h1, 2'd0, 32'h1);
        step("R10 idle lea", 0, 1, 1, 32'h9999, 1, 32'h1, 2'd0, 32'h1);

        for (int n = 0; n < 400; n++) begin
            step("R5 random", ($urandom % 4) != 0, $urandom % 2,
                 $urandom % 2, $urandom, $urandom % 2, $urandom,
                 2'($urandom % 4), $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule